// File: doc/BRIEF.md
# Protected Configuration Store Controller

This block manages the configuration storage of a programmable logic device: a small array of pattern words, a rewritable user signature of nine bytes (72 bits) and a one-way lock bit. A host sends commands over a single-cycle command port. Each command names an operation, a word or byte address and a data byte. Results come back on a response port as a one-cycle valid strobe, a 16-bit data word and an error flag.

Pattern words can only be written into locations that are blank (zero), so a pattern must be cleared before it is replaced. The lock bit, once set, makes every pattern read return zeros with the error flag. Only the multi-cycle bulk erase clears the lock bit. The signature can be read and rewritten at any time. The checksum walks every pattern word and every signature byte, one per cycle, so a change to the signature changes the checksum.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset every pattern word, every signature byte and the lock bit are zero, and busy, rspValid, errFlag and rspData are all low.
- R2: A command is taken at a rising edge where cmdValid is high and busy is low. The cmdOp codes are 1 erase, 2 write pattern, 3 write signature, 4 read pattern, 5 read signature, 6 checksum and 7 set lock. For codes 2, 3, 4, 5 and 7, rspValid is high for exactly the cycle after acceptance. Code 0 does nothing and gives no response.
- R3: A write-pattern command to a blank word stores cmdData at cmdAddr without error. A later read-pattern command returns that word, zero-extended, in rspData with errFlag low while the lock bit is clear.
- R4: A write-pattern command to a word that is not zero is refused. The response carries errFlag high and rspData zero, and the stored word keeps its old value.
- R5: The signature holds bytes 0 to 8, addressed by cmdAddr. They can be written and read back at any time, whether the lock bit is set or not. A signature address of 9 or above gives an error response and changes nothing.
- R6: A set-lock command sets the lock bit. From then on, each read-pattern command returns rspData zero with errFlag high.
- R7: Erase holds busy high for exactly ERASE_CYCLES cycles. It then clears all pattern words, all signature bytes and the lock bit, and raises rspValid in the first cycle in which busy is low again.
- R8: Checksum holds busy high for PAT_DEPTH+SIG_BYTES cycles. It then presents the sum modulo 2^16 of all pattern words and all signature bytes on rspData, with rspValid high in the first cycle in which busy is low.
- R9: Commands presented while busy is high are ignored and change no stored state. rspValid is never high while busy is high.
- R10: errFlag is high only together with rspValid, and rspData is zero whenever errFlag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Operation code |
| cmdAddr | input | ADDR_W | Pattern word or signature byte address |
| cmdData | input | DATA_W | Write data |
| busy | output | 1 | Erase or checksum in progress |
| rspValid | output | 1 | Response strobe |
| errFlag | output | 1 | Command refused |
| rspData | output | SUM_W | Read data or checksum |

## Verification
The pattern array is filled at every address with distinct nonzero values from an arithmetic formula, and each word is read back. This shows up address decode faults and lost writes. A second write to an occupied word must be refused, while the signature must accept a rewrite. Checksums are taken on the empty store, on the full store, and after a single signature byte changes; this tells apart a sum that skips the signature or some words from a correct one. Pattern and signature reads are repeated with the lock bit set and again after erase, which shows that the lock blocks only pattern reads and that only erase clears it. A signature write injected during a checksum shows whether commands are dropped while busy.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ERASE  = 3'd1,
    OP_WR_PAT = 3'd2,
    OP_WR_SIG = 3'd3,
    OP_RD_PAT = 3'd4,
    OP_RD_SIG = 3'd5,
    OP_CSUM   = 3'd6,
    OP_LOCK   = 3'd7
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_SUM   = 2'd2
  } ctrl_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPat;
    logic wrSig;
    logic setLock;
    logic clrAll;
    logic rspPat;
    logic rspSig;
    logic rspZero;
    logic sumClr;
    logic sumAdd;
    logic sumOut;
  } dp_strobe_t;

endpackage

// File: rtl/cfg_store_fsm.sv
module cfg_store_fsm
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int SIG_BYTES    = 9,
  parameter int ERASE_CYCLES = 6,
  parameter int TOTAL        = 25,
  parameter int IDX_W        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              patIsBlank,
  input  logic              locked,
  output dp_strobe_t        strb,
  output logic [IDX_W-1:0]  stepIdx,
  output logic              busy,
  output logic              rspValid,
  output logic              errFlag
);

  localparam int ERASE_W = $clog2(ERASE_CYCLES + 1);
  localparam int CNT_W   = (ERASE_W > IDX_W) ? ERASE_W : IDX_W;
  localparam logic [ADDR_W-1:0] SIG_LAST   = ADDR_W'(SIG_BYTES - 1);
  localparam logic [CNT_W-1:0]  ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0]  SUM_LAST   = CNT_W'(TOTAL - 1);

  ctrl_state_e       state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic              rspNxt, errNxt;
  logic              accept;
  logic              sigAddrOk;
  cmd_op_e           op;

  assign op        = cmd_op_e'(cmdOp);
  assign accept    = cmdValid && (state == ST_IDLE);
  assign sigAddrOk = (cmdAddr <= SIG_LAST);
  assign busy      = (state != ST_IDLE);
  assign stepIdx   = cnt[IDX_W-1:0];

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = cnt;
    rspNxt   = 1'b0;
    errNxt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_ERASE: begin
              stateNxt = ST_ERASE;
              cntNxt   = ERASE_LAST;
            end
            OP_WR_PAT: begin
              rspNxt       = 1'b1;
              strb.rspZero = 1'b1;
              if (patIsBlank) strb.wrPat = 1'b1;
              else            errNxt     = 1'b1;
            end
            OP_WR_SIG: begin
              rspNxt       = 1'b1;
              strb.rspZero = 1'b1;
              if (sigAddrOk) strb.wrSig = 1'b1;
              else           errNxt     = 1'b1;
            end
            OP_RD_PAT: begin
              rspNxt = 1'b1;
              if (locked) begin
                errNxt       = 1'b1;
                strb.rspZero = 1'b1;
              end else begin
                strb.rspPat = 1'b1;
              end
            end
            OP_RD_SIG: begin
              rspNxt = 1'b1;
              if (sigAddrOk) begin
                strb.rspSig = 1'b1;
              end else begin
                errNxt       = 1'b1;
                strb.rspZero = 1'b1;
              end
            end
            OP_CSUM: begin
              stateNxt    = ST_SUM;
              cntNxt      = '0;
              strb.sumClr = 1'b1;
            end
            OP_LOCK: begin
              rspNxt       = 1'b1;
              strb.rspZero = 1'b1;
              strb.setLock = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (cnt == '0) begin
          strb.clrAll  = 1'b1;
          strb.rspZero = 1'b1;
          rspNxt       = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_SUM: begin
        strb.sumAdd = 1'b1;
        if (cnt == SUM_LAST) begin
          strb.sumOut = 1'b1;
          rspNxt      = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rspValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      rspValid <= rspNxt;
      errFlag  <= errNxt;
    end
  end

endmodule

// File: rtl/cfg_store_datapath.sv
module cfg_store_datapath
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 9,
  parameter int SUM_W     = 16,
  parameter int PAT_DEPTH = 16,
  parameter int TOTAL     = 25,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              patIsBlank,
  output logic              locked,
  output logic [SUM_W-1:0]  rspData
);

  logic [DATA_W-1:0] patMem   [PAT_DEPTH];
  logic [7:0]        sigMem   [SIG_BYTES];
  logic [DATA_W-1:0] entryVec [TOTAL];
  logic              lockBit;
  logic [SUM_W-1:0]  sumAcc;
  logic [SUM_W-1:0]  entryExt;

  // Flat view of everything the checksum covers: pattern first, then signature
  for (genvar gi = 0; gi < PAT_DEPTH; gi++) begin : g_patEntry
    assign entryVec[gi] = patMem[gi];
  end
  for (genvar gj = 0; gj < SIG_BYTES; gj++) begin : g_sigEntry
    if (DATA_W >= 8) begin : g_wide
      assign entryVec[PAT_DEPTH + gj] = DATA_W'(sigMem[gj]);
    end else begin : g_narrow
      assign entryVec[PAT_DEPTH + gj] = sigMem[gj][DATA_W-1:0];
    end
  end

  assign entryExt   = SUM_W'(entryVec[stepIdx]);
  assign patIsBlank = (patMem[cmdAddr] == '0);
  assign locked     = lockBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAT_DEPTH; i++) patMem[i] <= '0;
      for (int j = 0; j < SIG_BYTES; j++) sigMem[j] <= '0;
      lockBit <= 1'b0;
      sumAcc  <= '0;
      rspData <= '0;
    end else begin
      if (strb.clrAll) begin
        for (int i = 0; i < PAT_DEPTH; i++) patMem[i] <= '0;
        for (int j = 0; j < SIG_BYTES; j++) sigMem[j] <= '0;
        lockBit <= 1'b0;
      end else begin
        if (strb.wrPat)   patMem[cmdAddr] <= cmdData;
        if (strb.wrSig)   sigMem[cmdAddr] <= 8'(cmdData);
        if (strb.setLock) lockBit <= 1'b1;
      end

      if (strb.sumClr)      sumAcc <= '0;
      else if (strb.sumAdd) sumAcc <= sumAcc + entryExt;

      if (strb.rspPat)       rspData <= SUM_W'(patMem[cmdAddr]);
      else if (strb.rspSig)  rspData <= SUM_W'(sigMem[cmdAddr]);
      else if (strb.sumOut)  rspData <= sumAcc + entryExt;
      else if (strb.rspZero) rspData <= '0;
    end
  end

endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int SIG_BYTES    = 9,
  parameter int ERASE_CYCLES = 6,
  parameter int SUM_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              rspValid,
  output logic              errFlag,
  output logic [SUM_W-1:0]  rspData
);

  localparam int PAT_DEPTH = 1 << ADDR_W;
  localparam int TOTAL     = PAT_DEPTH + SIG_BYTES;
  localparam int IDX_W     = $clog2(TOTAL);

  dp_strobe_t       strb;
  logic [IDX_W-1:0] stepIdx;
  logic             patIsBlank;
  logic             locked;

  cfg_store_fsm #(
    .ADDR_W(ADDR_W), .SIG_BYTES(SIG_BYTES), .ERASE_CYCLES(ERASE_CYCLES),
    .TOTAL(TOTAL), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .patIsBlank(patIsBlank), .locked(locked),
    .strb(strb), .stepIdx(stepIdx), .busy(busy),
    .rspValid(rspValid), .errFlag(errFlag)
  );

  cfg_store_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES), .SUM_W(SUM_W),
    .PAT_DEPTH(PAT_DEPTH), .TOTAL(TOTAL), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stepIdx(stepIdx),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .patIsBlank(patIsBlank),
    .locked(locked), .rspData(rspData)
  );

endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int SIG_BYTES    = 9,
  parameter int ERASE_CYCLES = 6,
  parameter int SUM_W        = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdData,
  input logic              busy,
  input logic              rspValid,
  input logic              errFlag,
  input logic [SUM_W-1:0]  rspData
);

  localparam int PAT_DEPTH = 1 << ADDR_W;
  localparam int MAX_BUSY  = (ERASE_CYCLES > PAT_DEPTH + SIG_BYTES) ?
                             ERASE_CYCLES : PAT_DEPTH + SIG_BYTES;
  localparam logic [ADDR_W-1:0] SIG_LAST = ADDR_W'(SIG_BYTES - 1);

  logic accept;
  logic busyQ;
  logic longIsErase;
  logic lockMirror;
  int   busyLen;

  assign accept = cmdValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      longIsErase <= 1'b0;
      lockMirror  <= 1'b0;
      busyLen     <= 0;
    end else begin
      busyQ <= busy;
      if (accept && cmdOp == 3'd1) longIsErase <= 1'b1;
      else if (accept && cmdOp == 3'd6) longIsErase <= 1'b0;
      if (accept && cmdOp == 3'd7) lockMirror <= 1'b1;
      else if (busy && !busyQ && 1'b0) lockMirror <= lockMirror;
      else if (busyQ && !busy && longIsErase) lockMirror <= 1'b0;
      busyLen <= busy ? busyLen + 1 : 0;
    end
  end

  // R2
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (cmdOp inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7})) |=> (rspValid && !busy));

  // R5
  sig_read_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 3'd5 && cmdAddr <= SIG_LAST) |=> (rspValid && !errFlag));

  // R6
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 3'd4 && lockMirror) |=> (errFlag && rspData == '0));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= MAX_BUSY);

  // R9
  no_rsp_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && rspValid));

  // R10
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> rspValid);

  // R10
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (rspData == '0));

endmodule

bind cfg_store_ctrl cfg_store_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES),
  .ERASE_CYCLES(ERASE_CYCLES), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdAddr(cmdAddr), .cmdData(cmdData), .busy(busy), .rspValid(rspValid),
  .errFlag(errFlag), .rspData(rspData)
);

// File: tb/cfg_store_ctrl_tb.sv
module cfg_store_ctrl_tb;

  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 8;
  localparam int SIG_BYTES    = 9;
  localparam int ERASE_CYCLES = 6;
  localparam int SUM_W        = 16;
  localparam int PAT_DEPTH    = 1 << ADDR_W;
  localparam int TOTAL        = PAT_DEPTH + SIG_BYTES;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic              busy, rspValid, errFlag;
  logic [SUM_W-1:0]  rspData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rv, rd, er, busyCycles;
  int expPat [PAT_DEPTH];
  int expSig [SIG_BYTES];

  always #4 clk = ~clk;

  cfg_store_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES),
    .ERASE_CYCLES(ERASE_CYCLES), .SUM_W(SUM_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .busy(busy),
    .rspValid(rspValid), .errFlag(errFlag), .rspData(rspData)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expSum();
    int s = 0;
    for (int i = 0; i < PAT_DEPTH; i++) s += expPat[i];
    for (int j = 0; j < SIG_BYTES; j++) s += expSig[j];
    return s % 65536;
  endfunction

  task automatic doCmd(input int op, input int addr, input int data);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op[2:0];
    cmdAddr  = addr[ADDR_W-1:0];
    cmdData  = data[DATA_W-1:0];
    @(negedge clk);
    cmdValid = 1'b0;
    busyCycles = 0;
    while (busy) begin
      busyCycles++;
      @(negedge clk);
    end
    rv = int'(rspValid);
    rd = int'(rspData);
    er = int'(errFlag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PAT_DEPTH; i++) expPat[i] = 0;
    for (int j = 0; j < SIG_BYTES; j++) expSig[j] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check("R1", "busy", int'(busy), 0);
    check("R1", "rspValid", int'(rspValid), 0);
    check("R1", "errFlag", int'(errFlag), 0);
    check("R1", "rspData", int'(rspData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 empty store reads back zeros
    doCmd(4, 5, 0);
    check("R1", "blank pattern word", rd, 0);
    doCmd(5, 8, 0);
    check("R1", "blank signature byte", rd, 0);

    // R8 checksum of empty store
    doCmd(6, 0, 0);
    check("R8", "empty sum valid", rv, 1);
    check("R8", "empty sum", rd, 0);
    check("R8", "sum busy cycles", busyCycles, TOTAL);

    // R2 code 0 gives no response
    doCmd(0, 1, 8'h33);
    check("R2", "nop rspValid", rv, 0);

    // R3 fill every word, then read all back
    for (int i = 0; i < PAT_DEPTH; i++) begin
      expPat[i] = (i * 37 + 5) % 256;
      doCmd(2, i, expPat[i]);
      check("R2", "write rspValid", rv, 1);
      check("R3", "write err", er, 0);
    end
    for (int i = 0; i < PAT_DEPTH; i++) begin
      doCmd(4, i, 0);
      check("R3", "read data", rd, expPat[i]);
      check("R3", "read err", er, 0);
    end

    // R4 rewrite of occupied word refused
    doCmd(2, 3, 8'h99);
    check("R4", "rewrite err", er, 1);
    check("R4", "rewrite data", rd, 0);
    doCmd(4, 3, 0);
    check("R4", "word unchanged", rd, expPat[3]);

    // R5 signature write, rewrite, out of range
    for (int j = 0; j < SIG_BYTES; j++) begin
      expSig[j] = 8'hA0 + j * 3;
      doCmd(3, j, expSig[j]);
      check("R5", "sig write err", er, 0);
    end
    expSig[2] = 8'h17;
    doCmd(3, 2, expSig[2]);
    check("R5", "sig rewrite err", er, 0);
    for (int j = 0; j < SIG_BYTES; j++) begin
      doCmd(5, j, 0);
      check("R5", "sig read", rd, expSig[j]);
    end
    doCmd(3, 9, 8'h44);
    check("R5", "sig addr 9 write err", er, 1);
    doCmd(5, 15, 0);
    check("R5", "sig addr 15 read err", er, 1);
    check("R10", "err data zero", rd, 0);

    // R8 full checksum, then after a signature change
    doCmd(6, 0, 0);
    check("R8", "full sum", rd, expSum());
    check("R8", "full sum busy", busyCycles, TOTAL);
    expSig[8] = 8'h01;
    doCmd(3, 8, expSig[8]);
    doCmd(6, 0, 0);
    check("R8", "sum after sig change", rd, expSum());

    // R9 signature write during checksum dropped
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd6; cmdAddr = '0; cmdData = '0;
    @(negedge clk);
    check("R9", "busy during sum", int'(busy), 1);
    cmdOp = 3'd3; cmdAddr = 4'd0; cmdData = 8'h55;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R9", "no rsp while busy", int'(rspValid), 0);
    while (busy) @(negedge clk);
    check("R9", "sum unaffected", int'(rspData), expSum());
    @(negedge clk);
    check("R9", "no late rsp", int'(rspValid), 0);
    doCmd(5, 0, 0);
    check("R9", "sig unchanged", rd, expSig[0]);

    // R6 lock blocks pattern reads only
    doCmd(7, 0, 0);
    check("R2", "lock rspValid", rv, 1);
    for (int i = 0; i < PAT_DEPTH; i++) begin
      doCmd(4, i, 0);
      check("R6", "locked read err", er, 1);
      check("R6", "locked read data", rd, 0);
    end
    doCmd(5, 4, 0);
    check("R5", "sig read while locked", rd, expSig[4]);
    check("R5", "sig read err while locked", er, 0);
    expSig[4] = 8'h6C;
    doCmd(3, 4, expSig[4]);
    doCmd(5, 4, 0);
    check("R5", "sig rewrite while locked", rd, expSig[4]);

    // R7 erase clears everything, lock included
    doCmd(1, 0, 0);
    check("R7", "erase busy cycles", busyCycles, ERASE_CYCLES);
    check("R7", "erase rspValid", rv, 1);
    for (int i = 0; i < PAT_DEPTH; i++) expPat[i] = 0;
    for (int j = 0; j < SIG_BYTES; j++) expSig[j] = 0;
    for (int i = 0; i < PAT_DEPTH; i++) begin
      doCmd(4, i, 0);
      check("R7", "erased word", rd, 0);
      check("R7", "unlocked read err", er, 0);
    end
    doCmd(5, 2, 0);
    check("R7", "erased sig", rd, 0);
    doCmd(6, 0, 0);
    check("R7", "erased sum", rd, 0);
    expPat[3] = 8'h99;
    doCmd(2, 3, expPat[3]);
    check("R7", "write after erase err", er, 0);
    doCmd(4, 3, 0);
    check("R7", "write after erase data", rd, expPat[3]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule